// File: doc/BRIEF.md
# Multi-Mode Host Bus Interface

This block is the host-facing register port of a peripheral controller. One port serves four processor bus styles: a 16-bit direction-plus-strobe bus with an acknowledge, two 16-bit buses with separate read and write strobes, and an 8-bit bus with separate read and write strobes. Two static mode pins pick the style. Every host access becomes a read or a write of a 32-bit I/O buffer, which is built from an upper 16-bit word and a lower 16-bit word. The buffer contents are presented to the controller core on `iobuf`.

All host control inputs cross into the internal clock domain through a two-stage synchronizer. The synchronized strobes drive a three-state machine. `ST_IDLE` waits for a decoded access. `ST_IDLE -> ST_WR` is taken on a write request, and the buffer is updated on that transition. `ST_IDLE -> ST_RD` is taken on a read request when no write is requested. `ST_RD -> ST_IDLE` and `ST_WR -> ST_IDLE` are taken when the host releases its strobe. The handshake output and the data output enables come from the state. A reset qualifier accepts a reset only after the reset input has been low for a set number of consecutive clocks, and the mode pins are captured only while reset is active.

Top module: `hostbus_port`

## Requirements
- R1: The mode is captured from `mode_sel` only while the qualified reset is active. Changing `mode_sel` after reset has no effect on the decoding, the word order or the handshake. The encodings are 2'b00 strobe/acknowledge, 2'b01 RD/WR word-swapped, 2'b10 RD/WR with ready, and 2'b11 8-bit.
- R2: Reset takes effect only after `rst_n` has been sampled low on 8 consecutive rising edges. A pulse of 7 low cycles leaves the buffer and the mode unchanged. A qualified reset clears `iobuf` to 0 and deasserts `host_ack`, `host_ready`, `host_oe_lo` and `host_oe_hi`, with `host_dout` at 0.
- R3: In mode 2'b00, `host_strobe_n` low with `host_rw`=1 is a read, and `host_strobe_n` low with `host_rw`=0 is a write. `host_ack` rises on the 3rd rising edge after the strobe falls, stays high while the strobe is held, and falls on the 3rd rising edge after the strobe is released.
- R4: In modes 2'b01, 2'b10 and 2'b11, `host_rd_n` low is a read and `host_wr_n` low is a write, and `host_rw`/`host_strobe_n` are ignored. If both strobes are low, the write wins.
- R5: In modes 2'b00 and 2'b01, `host_addr[0]`=0 selects `iobuf[31:16]` and `host_addr[0]`=1 selects `iobuf[15:0]`, for reads and for writes.
- R6: In mode 2'b10, `host_addr[0]`=0 selects `iobuf[15:0]` and `host_addr[0]`=1 selects `iobuf[31:16]`.
- R7: In mode 2'b10, `host_ready` follows the same timing as `host_ack` in R3, measured from the RD or WR strobe. `host_ready` is 0 in every other mode, and `host_ack` is 0 in every mode except 2'b00.
- R8: In mode 2'b11, `host_addr[1:0]`=n selects byte `iobuf[8n+7:8n]`. Writes take only `host_din[7:0]`. On reads `host_oe_hi` stays 0 and `host_dout[15:8]` is 0.
- R9: `host_oe_lo` (and `host_oe_hi` in 16-bit modes) is high only while the port is in the read state, with the same timing as the handshake. It is never high during a write. `host_dout` is 0 whenever `host_oe_lo` is low.
- R10: A write commits once, on the synchronized falling edge of the write strobe. Changing `host_din` while the strobe is still held does not change `iobuf`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low reset request, qualified by length |
| mode_sel | input | 2 | Bus style select, captured during reset |
| host_addr | input | 2 | Host address (bit 0 for word, both bits for byte) |
| host_rw | input | 1 | Direction in mode 00, 1 = read |
| host_strobe_n | input | 1 | Active-low data strobe in mode 00 |
| host_rd_n | input | 1 | Active-low read strobe in modes 01/10/11 |
| host_wr_n | input | 1 | Active-low write strobe in modes 01/10/11 |
| host_din | input | 16 | Write data from the host |
| host_dout | output | 16 | Read data to the host |
| host_oe_lo | output | 1 | Output enable, data lines 7..0 |
| host_oe_hi | output | 1 | Output enable, data lines 15..8 |
| host_ack | output | 1 | Cycle acknowledge, mode 00 |
| host_ready | output | 1 | Ready handshake, mode 10 |
| iobuf | output | 32 | I/O buffer contents toward the core |

## Verification
The same pair of addresses is written with distinct words in every mode, and the result is read back. Because of that, the `iobuf` image tells big-endian from little-endian word order and word steering from byte steering. In the 8-bit mode the bench drives non-zero upper data lines, which shows whether they leak into the buffer or onto the bus. It also changes the data while a write strobe is still held, which separates an edge-triggered commit from a level-triggered one. Reset pulses of 7 and 8 cycles check the qualifier at its boundary, and a mode-pin change after reset must leave the mapping and handshake unchanged.

// File: rtl/hb_pkg.sv
package hb_pkg;
    typedef enum logic [1:0] {
        MODE_SDS  = 2'b00,
        MODE_RWA  = 2'b01,
        MODE_RWB  = 2'b10,
        MODE_BYTE = 2'b11
    } hb_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_RD   = 2'b01,
        ST_WR   = 2'b10
    } hb_state_e;
endpackage

// File: rtl/hb_rst_qual.sv
module hb_rst_qual #(
    parameter int RST_LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic blk_rst
);
    localparam int CNT_W = $clog2(RST_LEN + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RST_LEN - 1);

    logic [CNT_W-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst_n) begin
            low_cnt <= '0;
            blk_rst <= 1'b0;
        end else if (low_cnt != LAST) begin
            low_cnt <= low_cnt + 1'b1;
        end else begin
            blk_rst <= 1'b1;
        end
    end
endmodule

// File: rtl/hb_sync.sv
module hb_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         blk_rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (blk_rst) stg[i] <= '1;
                    else         stg[i] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (blk_rst) stg[i] <= '1;
                    else         stg[i] <= stg[i-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/hb_lane_map.sv
module hb_lane_map
    import hb_pkg::*;
#(
    parameter int DW = 16
) (
    input  hb_mode_e               mode,
    input  logic [$clog2(2*DW/8)-1:0] addr,
    input  logic [DW-1:0]          din,
    input  logic [2*DW-1:0]        buf_q,
    output logic [2*DW-1:0]        wr_mask,
    output logic [2*DW-1:0]        wr_data,
    output logic [DW-1:0]          rd_data
);
    localparam int BUF_W = 2 * DW;
    localparam int BW    = 8;
    localparam int NB    = BUF_W / BW;

    logic            hi_word;
    logic [BUF_W-1:0] shifted;

    always_comb begin
        hi_word = (mode == MODE_SDS || mode == MODE_RWA) ? !addr[0] : addr[0];
        shifted = buf_q >> (int'(addr) * BW);
        if (mode == MODE_BYTE) begin
            wr_mask = BUF_W'({BW{1'b1}}) << (int'(addr) * BW);
            wr_data = {NB{din[BW-1:0]}};
            rd_data = {{(DW-BW){1'b0}}, shifted[BW-1:0]};
        end else begin
            wr_mask = hi_word ? {{DW{1'b1}}, {DW{1'b0}}} : {{DW{1'b0}}, {DW{1'b1}}};
            wr_data = {din, din};
            rd_data = hi_word ? buf_q[BUF_W-1:DW] : buf_q[DW-1:0];
        end
    end
endmodule

// File: rtl/hostbus_port.sv
module hostbus_port
    import hb_pkg::*;
#(
    parameter int DW          = 16,
    parameter int RST_LEN     = 8,
    parameter int SYNC_STAGES = 2,
    localparam int BUF_W      = 2 * DW,
    localparam int ADDR_W     = $clog2(BUF_W / 8)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_sel,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_rw,
    input  logic              host_strobe_n,
    input  logic              host_rd_n,
    input  logic              host_wr_n,
    input  logic [DW-1:0]     host_din,
    output logic [DW-1:0]     host_dout,
    output logic              host_oe_lo,
    output logic              host_oe_hi,
    output logic              host_ack,
    output logic              host_ready,
    output logic [BUF_W-1:0]  iobuf
);
    logic      blk_rst;
    hb_mode_e  mode_q;
    hb_state_e state_q, state_d;
    logic      s_rw, s_strb_n, s_rd_n, s_wr_n;
    logic      rd_req, wr_req, commit;
    logic [BUF_W-1:0] wr_mask, wr_data;
    logic [DW-1:0]    rd_data;

    hb_rst_qual #(.RST_LEN(RST_LEN)) u_rst (
        .clk     (clk),
        .rst_n   (rst_n),
        .blk_rst (blk_rst)
    );

    hb_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .blk_rst (blk_rst),
        .d       ({host_rw, host_strobe_n, host_rd_n, host_wr_n}),
        .q       ({s_rw, s_strb_n, s_rd_n, s_wr_n})
    );

    hb_lane_map #(.DW(DW)) u_map (
        .mode    (mode_q),
        .addr    (host_addr),
        .din     (host_din),
        .buf_q   (iobuf),
        .wr_mask (wr_mask),
        .wr_data (wr_data),
        .rd_data (rd_data)
    );

    always_ff @(posedge clk) begin
        if (blk_rst) mode_q <= hb_mode_e'(mode_sel);
    end

    always_comb begin
        if (mode_q == MODE_SDS) begin
            rd_req = !s_strb_n && s_rw;
            wr_req = !s_strb_n && !s_rw;
        end else begin
            rd_req = !s_rd_n;
            wr_req = !s_wr_n;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_req)      state_d = ST_WR;
                else if (rd_req) state_d = ST_RD;
            end
            ST_RD:   if (!rd_req) state_d = ST_IDLE;
            ST_WR:   if (!wr_req) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (blk_rst) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    always_comb begin
        commit     = (state_q == ST_IDLE) && wr_req;
        host_ack   = (state_q != ST_IDLE) && (mode_q == MODE_SDS);
        host_ready = (state_q != ST_IDLE) && (mode_q == MODE_RWB);
        host_oe_lo = (state_q == ST_RD);
        host_oe_hi = (state_q == ST_RD) && (mode_q != MODE_BYTE);
        host_dout  = host_oe_lo ? rd_data : '0;
    end

    always_ff @(posedge clk) begin
        if (blk_rst)     iobuf <= '0;
        else if (commit) iobuf <= (iobuf & ~wr_mask) | (wr_data & wr_mask);
    end
endmodule

// File: rtl/hostbus_port_chk.sv
module hostbus_port_chk
    import hb_pkg::*;
#(
    parameter int BUF_W = 32
) (
    input logic             clk,
    input logic             blk_rst,
    input hb_mode_e         mode_q,
    input hb_state_e        state_q,
    input logic             rd_req,
    input logic             wr_req,
    input logic             host_ack,
    input logic             host_ready,
    input logic             host_oe_lo,
    input logic             host_oe_hi,
    input logic [BUF_W-1:0] iobuf
);
    assert_mode_frozen_R1: assert property (@(posedge clk) disable iff (blk_rst)
        !$past(blk_rst) |-> $stable(mode_q));

    assert_ack_only_sds_R3: assert property (@(posedge clk) disable iff (blk_rst)
        host_ack |-> mode_q == MODE_SDS);

    assert_ack_release_R3: assert property (@(posedge clk) disable iff (blk_rst)
        (host_ack && !rd_req && !wr_req) |=> !host_ack);

    assert_ready_only_rwb_R7: assert property (@(posedge clk) disable iff (blk_rst)
        host_ready |-> mode_q == MODE_RWB);

    assert_hs_exclusive_R7: assert property (@(posedge clk) disable iff (blk_rst)
        !(host_ack && host_ready));

    assert_byte_hi_off_R8: assert property (@(posedge clk) disable iff (blk_rst)
        (mode_q == MODE_BYTE) |-> !host_oe_hi);

    assert_oe_after_read_R9: assert property (@(posedge clk) disable iff (blk_rst)
        $rose(host_oe_lo) |-> $past(rd_req) && !$past(wr_req));

    assert_buf_hold_R10: assert property (@(posedge clk) disable iff (blk_rst)
        (state_q != ST_IDLE) |=> $stable(iobuf));
endmodule

bind hostbus_port hostbus_port_chk #(.BUF_W(BUF_W)) u_chk (
    .clk        (clk),
    .blk_rst    (blk_rst),
    .mode_q     (mode_q),
    .state_q    (state_q),
    .rd_req     (rd_req),
    .wr_req     (wr_req),
    .host_ack   (host_ack),
    .host_ready (host_ready),
    .host_oe_lo (host_oe_lo),
    .host_oe_hi (host_oe_hi),
    .iobuf      (iobuf)
);

// File: tb/hostbus_port_bench.sv
`timescale 1ns/1ps
module hostbus_port_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_sel = 2'b00;
    logic [1:0]  host_addr = 2'b00;
    logic        host_rw = 1'b1;
    logic        host_strobe_n = 1'b1;
    logic        host_rd_n = 1'b1;
    logic        host_wr_n = 1'b1;
    logic [15:0] host_din = 16'h0;
    logic [15:0] host_dout;
    logic        host_oe_lo, host_oe_hi, host_ack, host_ready;
    logic [31:0] iobuf;

    int checks = 0;
    int errors = 0;
    logic [1:0]  cur_mode = 2'b00;
    logic [31:0] exp_buf = 32'h0;

    always #4 clk = ~clk;

    hostbus_port u_hostbus_port (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .host_addr(host_addr),
        .host_rw(host_rw), .host_strobe_n(host_strobe_n), .host_rd_n(host_rd_n),
        .host_wr_n(host_wr_n), .host_din(host_din), .host_dout(host_dout),
        .host_oe_lo(host_oe_lo), .host_oe_hi(host_oe_hi), .host_ack(host_ack),
        .host_ready(host_ready), .iobuf(iobuf)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] model_wr(input logic [1:0] m, input logic [1:0] a,
                                             input logic [15:0] d, input logic [31:0] old);
        logic [31:0] r = old;
        unique case (m)
            2'b00, 2'b01: if (a[0]) r[15:0] = d; else r[31:16] = d;
            2'b10:        if (a[0]) r[31:16] = d; else r[15:0] = d;
            default:      r[a*8 +: 8] = d[7:0];
        endcase
        return r;
    endfunction

    function automatic logic [15:0] model_rd(input logic [1:0] m, input logic [1:0] a, input logic [31:0] b);
        unique case (m)
            2'b00, 2'b01: return a[0] ? b[15:0] : b[31:16];
            2'b10:        return a[0] ? b[31:16] : b[15:0];
            default:      return {8'h00, b[a*8 +: 8]};
        endcase
    endfunction

    task automatic hs_check(input string req, input logic on);
        check(req, "ack", host_ack, on && cur_mode == 2'b00);
        check(req, "ready", host_ready, on && cur_mode == 2'b10);
    endtask

    task automatic do_reset(input int n, input logic [1:0] m);
        @(negedge clk);
        mode_sel = m;
        rst_n = 1'b0;
        repeat (n) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        if (n >= 8) begin
            cur_mode = m;
            exp_buf = 32'h0;
        end
    endtask

    task automatic strobe(input logic wr, input logic on);
        if (on) begin
            host_rw = !wr;
            host_strobe_n = !(cur_mode == 2'b00);
            host_rd_n = !(cur_mode != 2'b00 && !wr);
            host_wr_n = !(cur_mode != 2'b00 && wr);
        end else begin
            host_strobe_n = 1'b1;
            host_rd_n = 1'b1;
            host_wr_n = 1'b1;
        end
    endtask

    task automatic host_write(input string req, input logic [1:0] a, input logic [15:0] d);
        host_addr = a;
        host_din = d;
        strobe(1'b1, 1'b1);
        repeat (2) @(negedge clk);
        hs_check(req, 1'b0);
        @(negedge clk);
        hs_check(req, 1'b1);
        check("R9", "oe_lo during write", host_oe_lo, 1'b0);
        exp_buf = model_wr(cur_mode, a, d, exp_buf);
        host_din = ~d;
        repeat (3) @(negedge clk);
        check("R10", "buffer after held-strobe data change", iobuf, exp_buf);
        check("R9", "oe_hi during write", host_oe_hi, 1'b0);
        strobe(1'b1, 1'b0);
        repeat (2) @(negedge clk);
        hs_check(req, 1'b1);
        @(negedge clk);
        hs_check(req, 1'b0);
        check(req, "iobuf after write", iobuf, exp_buf);
    endtask

    task automatic host_read(input string req, input logic [1:0] a);
        host_addr = a;
        strobe(1'b0, 1'b1);
        repeat (2) @(negedge clk);
        check("R9", "oe before decode", host_oe_lo, 1'b0);
        check("R9", "dout idle", host_dout, 16'h0);
        @(negedge clk);
        hs_check(req, 1'b1);
        check("R9", "oe_lo in read", host_oe_lo, 1'b1);
        check("R8", "oe_hi lane", host_oe_hi, cur_mode != 2'b11);
        check(req, "read data", host_dout, model_rd(cur_mode, a, exp_buf));
        strobe(1'b0, 1'b0);
        repeat (3) @(negedge clk);
        hs_check(req, 1'b0);
        check("R9", "oe after release", host_oe_lo, 1'b0);
    endtask

    task automatic test_reset_state();
        do_reset(8, 2'b00);
        check("R2", "iobuf after reset", iobuf, 32'h0);
        check("R2", "ack after reset", host_ack, 1'b0);
        check("R2", "ready after reset", host_ready, 1'b0);
        check("R2", "oe after reset", {host_oe_hi, host_oe_lo}, 2'b00);
        check("R2", "dout after reset", host_dout, 16'h0);
    endtask

    task automatic test_mode(input logic [1:0] m, input string req);
        do_reset(8, m);
        host_write(req, 2'b00, 16'hA1B2);
        host_write(req, 2'b01, 16'hC3D4);
        host_read(req, 2'b00);
        host_read(req, 2'b01);
    endtask

    task automatic test_byte_mode();
        do_reset(8, 2'b11);
        host_write("R8", 2'b00, 16'hFF11);
        host_write("R8", 2'b01, 16'hEE22);
        host_write("R8", 2'b10, 16'hDD33);
        host_write("R8", 2'b11, 16'hCC44);
        check("R8", "byte image", iobuf, 32'h44332211);
        host_read("R8", 2'b10);
        check("R8", "upper data lines idle", host_dout[15:8], 8'h00);
        host_read("R8", 2'b11);
    endtask

    task automatic test_ignored_pins();
        do_reset(8, 2'b01);
        host_rw = 1'b0;
        host_strobe_n = 1'b0;
        repeat (5) @(negedge clk);
        check("R4", "dir/strobe ignored in RD/WR mode", iobuf, 32'h0);
        check("R4", "no read state from strobe", host_oe_lo, 1'b0);
        host_strobe_n = 1'b1;
        host_rw = 1'b1;
        @(negedge clk);
        host_write("R4", 2'b00, 16'h1234);
        check("R5", "word order mode 01", iobuf, 32'h12340000);
    endtask

    task automatic test_mode_pins_after_reset();
        do_reset(8, 2'b00);
        mode_sel = 2'b10;
        @(negedge clk);
        host_write("R1", 2'b00, 16'h5A5A);
        check("R1", "mapping kept after pin change", iobuf, 32'h5A5A0000);
    endtask

    task automatic test_short_reset();
        do_reset(8, 2'b10);
        host_write("R6", 2'b00, 16'h7777);
        check("R6", "little-endian low word", iobuf, 32'h00007777);
        do_reset(7, 2'b00);
        check("R2", "7-cycle pulse keeps buffer", iobuf, 32'h00007777);
        host_write("R2", 2'b01, 16'h8888);
        check("R2", "mode kept after short pulse", iobuf, 32'h88887777);
        do_reset(8, 2'b00);
        check("R2", "8-cycle pulse clears buffer", iobuf, 32'h0);
    endtask

    initial begin
        test_reset_state();
        test_mode(2'b00, "R3");
        check("R5", "big-endian image mode 00", iobuf, 32'hA1B2C3D4);
        test_mode(2'b01, "R4");
        check("R5", "big-endian image mode 01", iobuf, 32'hA1B2C3D4);
        test_mode(2'b10, "R7");
        check("R6", "little-endian image mode 10", iobuf, 32'hC3D4A1B2);
        test_byte_mode();
        test_ignored_pins();
        test_mode_pins_after_reset();
        test_short_reset();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule